// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter

This block sends bytes on a single serial line using 8N1 framing. It has a one-byte holding buffer in front of a frame shift register, so software can load the next byte while the current one is still going out. When a frame finishes and another byte is waiting, the next frame follows with no idle time on the line.

Two status flags report progress:
- **Empty flag**: a level that stays high while the holding buffer can take a byte.
- **Done flag**: a sticky flag that sets when the line has gone quiet with nothing left to send. Two strobes can clear it: a clear-by-write-one strobe and an interrupt-acknowledge strobe.

Each flag has an enable that gates it onto its own interrupt request. The block takes bit timing from an external baud tick. A bit lasts 16 ticks, or 8 ticks when the speed-double control is set.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `tx_out` is 1, `empty_flag` is 1 and `done_flag` is 0. `tx_out` stays 1 whenever no frame is being shifted.
- R2: Each frame on `tx_out` is one low start bit, then 8 data bits with bit 0 first, then one high stop bit.
- R3: A write (`wr_en` high for one clock) clears `empty_flag` at the next clock edge. `empty_flag` sets again in the cycle after the buffered byte moves into the shift register.
- R4: `empty_irq` is high exactly while both `empty_ie` and `empty_flag` are high.
- R5: `done_flag` sets when a stop bit ends and the holding buffer is empty. It does not set at the end of a frame that is followed by a buffered byte.
- R6: A one-clock pulse on `done_clr` or on `irq_ack` clears `done_flag`. If a frame ends in the same cycle, the set wins.
- R7: `done_irq` is high exactly while both `done_ie` and `done_flag` are high.
- R8: With `dbl_speed` low, a bit lasts 16 `baud_tick` pulses. With `dbl_speed` high, it lasts 8.
- R9: If a byte is waiting when a stop bit ends, the next start bit begins in the very next cycle. Two back-to-back frames therefore start exactly 10 bit times apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock baud enable pulse |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| wr_en | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| done_clr | input | 1 | Write-one clear strobe for the done flag |
| irq_ack | input | 1 | Interrupt-acknowledge strobe, clears the done flag |
| empty_ie | input | 1 | Enable for the empty interrupt |
| done_ie | input | 1 | Enable for the done interrupt |
| tx_out | output | 1 | Serial line, idles high |
| empty_flag | output | 1 | Holding buffer can accept a byte |
| done_flag | output | 1 | Transmission finished, nothing pending |
| empty_irq | output | 1 | Empty interrupt request |
| done_irq | output | 1 | Done interrupt request |

## Verification
The assertions check on every cycle that:
- the line is high whenever the shifter is idle;
- a write always leaves the empty flag low after the next edge;
- the done flag only rises after a high stop-bit cycle and while the buffer is empty;
- the clear strobes take effect unless a frame end arrives in the same cycle.

The rest can only be shown by the bench's scenarios, which decode frames and compare them against the written bytes:
- that each frame carries the right bits in the right order;
- bit lengths under both speed settings and under sparse baud ticks;
- exact back-to-back spacing;
- interrupt gating with each enable.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 2;
  typedef enum logic {TX_IDLE = 1'b0, TX_SEND = 1'b1} tx_state_e;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int unsigned DIV_NORM = 16,
  parameter int unsigned DIV_FAST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  input  logic fast,
  output logic bit_end
);
  localparam int unsigned CNT_W = $clog2(DIV_NORM);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim     = fast ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_NORM - 1);
    bit_end = run && tick && (cnt_q >= lim);
    cnt_d   = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (run && tick) begin
      cnt_d = bit_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tx_holding.sv
module tx_holding #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] hold_data,
  output logic          hold_full
);
  logic [DW-1:0] data_d;
  logic          full_d;

  always_comb begin
    data_d = wr_en ? wr_data : hold_data;
    if (wr_en)     full_d = 1'b1;
    else if (take) full_d = 1'b0;
    else           full_d = hold_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else begin
      hold_data <= data_d;
      hold_full <= full_d;
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          bit_end,
  output logic          take,
  output logic          busy,
  output logic          frame_done,
  output logic          tx_bit
);
  localparam int unsigned FW    = DW + 2;
  localparam int unsigned IDX_W = $clog2(FW);

  tx_state_e        st_q, st_d;
  logic [FW-1:0]    sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             stop_end;

  always_comb begin
    busy       = (st_q == TX_SEND);
    stop_end   = busy && bit_end && (idx_q == IDX_W'(FW - 1));
    take       = hold_full && (!busy || stop_end);
    frame_done = stop_end && !hold_full;
    tx_bit     = busy ? sh_q[0] : 1'b1;
    st_d  = st_q;
    sh_d  = sh_q;
    idx_d = idx_q;
    if (take) begin
      st_d  = TX_SEND;
      sh_d  = {1'b1, hold_data, 1'b0};
      idx_d = '0;
    end else if (stop_end) begin
      st_d = TX_IDLE;
    end else if (busy && bit_end) begin
      sh_d  = {1'b1, sh_q[FW-1:1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      sh_q  <= '1;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/tx_status.sv
module tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic done_clr,
  input  logic irq_ack,
  input  logic hold_full,
  input  logic empty_ie,
  input  logic done_ie,
  output logic empty_flag,
  output logic done_flag,
  output logic empty_irq,
  output logic done_irq
);
  logic done_d;

  always_comb begin
    if (frame_done)              done_d = 1'b1;
    else if (done_clr || irq_ack) done_d = 1'b0;
    else                          done_d = done_flag;
    empty_flag = !hold_full;
    empty_irq  = empty_ie && empty_flag;
    done_irq   = done_ie && done_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_flag <= 1'b0;
    else        done_flag <= done_d;
  end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_NORM = 16,
  parameter int unsigned TICKS_FAST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              dbl_speed,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done_clr,
  input  logic              irq_ack,
  input  logic              empty_ie,
  input  logic              done_ie,
  output logic              tx_out,
  output logic              empty_flag,
  output logic              done_flag,
  output logic              empty_irq,
  output logic              done_irq
);
  logic [DATA_W-1:0] hold_data;
  logic hold_full, take, busy, frame_done, bit_end;

  tx_holding #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .hold_data(hold_data), .hold_full(hold_full)
  );

  tx_bit_timer #(.DIV_NORM(TICKS_NORM), .DIV_FAST(TICKS_FAST)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(take), .run(busy),
    .tick(baud_tick), .fast(dbl_speed), .bit_end(bit_end)
  );

  tx_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold_full(hold_full), .hold_data(hold_data),
    .bit_end(bit_end), .take(take), .busy(busy),
    .frame_done(frame_done), .tx_bit(tx_out)
  );

  tx_status u_stat (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .done_clr(done_clr),
    .irq_ack(irq_ack), .hold_full(hold_full), .empty_ie(empty_ie),
    .done_ie(done_ie), .empty_flag(empty_flag), .done_flag(done_flag),
    .empty_irq(empty_irq), .done_irq(done_irq)
  );
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic done_clr,
  input logic irq_ack,
  input logic empty_ie,
  input logic tx_out,
  input logic empty_flag,
  input logic done_flag,
  input logic empty_irq,
  input logic busy,
  input logic frame_done
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out);

  // R3
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty_flag);

  // R4
  empty_irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(empty_flag) && empty_ie) |-> empty_irq);

  // R5
  done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> ($past(tx_out) && empty_flag));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_clr || irq_ack) && !frame_done) |=> !done_flag);

  // R6
  done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> done_flag);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .done_clr(done_clr),
  .irq_ack(irq_ack), .empty_ie(empty_ie), .tx_out(tx_out),
  .empty_flag(empty_flag), .done_flag(done_flag), .empty_irq(empty_irq),
  .busy(busy), .frame_done(frame_done)
);

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic dbl_speed = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic done_clr = 1'b0;
  logic irq_ack = 1'b0;
  logic empty_ie = 1'b1;
  logic done_ie = 1'b1;
  logic tx_out, empty_flag, done_flag, empty_irq, done_irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tick_div = 1;
  int tcnt = 0;
  int prev_start = 0;
  int gap = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  uart_tx_dbuf dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .dbl_speed(dbl_speed),
    .wr_en(wr_en), .wr_data(wr_data), .done_clr(done_clr), .irq_ack(irq_ack),
    .empty_ie(empty_ie), .done_ie(done_ie), .tx_out(tx_out),
    .empty_flag(empty_flag), .done_flag(done_flag), .empty_irq(empty_irq),
    .done_irq(done_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin
      tcnt <= 0;
      baud_tick <= 1'b1;
    end else begin
      tcnt <= tcnt + 1;
      baud_tick <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (dbl_speed ? 8 : 16) * tick_div;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: decodes frames and compares against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !tx_out) begin
        logic [7:0] got;
        int bc;
        bc = bit_clks();
        gap = cyc - prev_start;
        prev_start = cyc;
        repeat (bc / 2) @(negedge clk);
        chk(tx_out == 1'b0, "R2 start bit", tx_out, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bc) @(negedge clk);
          got[i] = tx_out;
        end
        repeat (bc) @(negedge clk);
        chk(tx_out == 1'b1, "R2 stop bit", tx_out, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", got, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R2/R8 frame data", got, e);
        end
      end
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    exp_q.push_back(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_flag && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done_flag == 1'b1, "R5 done flag sets", done_flag, 1);
  endtask

  task automatic pulse_clr(input bit use_ack);
    @(negedge clk);
    if (use_ack) irq_ack = 1'b1; else done_clr = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    done_clr = 1'b0;
    chk(done_flag == 1'b0, use_ack ? "R6 ack clears done" : "R6 write-one clears done", done_flag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_out == 1'b1, "R1 line idle high", tx_out, 1);
    chk(empty_flag == 1'b1, "R1 empty after reset", empty_flag, 1);
    chk(done_flag == 1'b0, "R1 done clear after reset", done_flag, 0);
    chk(empty_irq == 1'b1, "R4 empty irq with enable", empty_irq, 1);
    chk(done_irq == 1'b0, "R7 done irq low", done_irq, 0);

    // Single frame, normal speed
    write_byte(8'hA5);
    chk(empty_flag == 1'b0, "R3 write clears empty", empty_flag, 0);
    chk(empty_irq == 1'b0, "R4 irq drops with flag", empty_irq, 0);
    @(negedge clk);
    chk(empty_flag == 1'b1, "R3 empty after move to shifter", empty_flag, 1);
    wait_done();
    chk(done_irq == 1'b1, "R7 done irq with enable", done_irq, 1);
    pulse_clr(1'b0);

    // Back-to-back, normal speed, tick every clock
    write_byte(8'h3C);
    @(negedge clk);
    write_byte(8'hC3);
    chk(empty_flag == 1'b0, "R3 empty low while buffered", empty_flag, 0);
    repeat (170) @(negedge clk);
    chk(done_flag == 1'b0, "R5 no done between chained frames", done_flag, 0);
    done_ie = 1'b0;
    wait_done();
    chk(gap == 160, "R9 back-to-back spacing", gap, 160);
    chk(done_irq == 1'b0, "R7 done irq masked", done_irq, 0);
    pulse_clr(1'b1);
    done_ie = 1'b1;

    // Double speed back-to-back
    dbl_speed = 1'b1;
    write_byte(8'h81);
    @(negedge clk);
    write_byte(8'h7E);
    wait_done();
    chk(gap == 80, "R8 double speed bit length", gap, 80);
    pulse_clr(1'b0);

    // Sparse ticks at both speeds
    tick_div = 3;
    dbl_speed = 1'b0;
    write_byte(8'h5A);
    wait_done();
    pulse_clr(1'b1);
    dbl_speed = 1'b1;
    write_byte(8'hFF);
    @(negedge clk);
    write_byte(8'h00);
    empty_ie = 1'b0;
    @(negedge clk);
    chk(empty_irq == 1'b0, "R4 empty irq masked", empty_irq, 0);
    wait_done();
    pulse_clr(1'b0);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    chk(tx_out == 1'b1, "R1 line high after traffic", tx_out, 1);
    finish_run();
  end
endmodule